// File: doc/BRIEF.md
# Multi-Channel Compare Event Timer

The block holds one free-running up-counter and a parameterised set of comparator channels that watch it. Software drives everything through a plain register bus: a write strobe with address and data takes effect on the next clock edge, and a read strobe loads the addressed word into the read-data register on the next clock edge. Each channel raises its own interrupt line when the counter reaches its comparator. A channel either fires once and waits for a new comparator value, or it adds a stored period after every match and keeps firing without further writes.

The register space holds a read-only capability word, a global configuration word whose bit 0 starts and stops the counter, the counter itself, and a level-interrupt status word. Each channel then has a configuration word and a comparator word. Channel `n` has its configuration word at word address `8 + 2n` and its comparator word at `9 + 2n`. The capability word is at address 0, the global configuration at 1, the counter at 2 and the status word at 3. Data words are 64 bits wide. Only register accesses move data, so no port on the block uses a valid/ready handshake. Every pin is a plain control or status pin, and the bus never stalls.

Top module: `evt_timer`

## Requirements
- R1: The capability word at address 0 is read-only. It holds the counter tick period in femtoseconds in bits 63:32. Bit 13 is 1 when the counter is 64 bits wide. Bits 12:8 hold the channel count minus one. Every other bit reads 0.
- R2: Reset stops the counter and clears every writable register. While bit 0 of the global configuration word (address 1) is 1, the counter advances by one on every clock. While that bit is 0, the counter holds its value.
- R3: A write to the counter (address 2) loads the value only while the counter is stopped. While the counter runs, such a write has no effect.
- R4: The channel configuration word has these bits: bit 0 interrupt enable, bit 1 periodic select, bit 2 level type (1) or edge type (0), bit 3 32-bit compare, bit 4 value-set, and bit 5 a read-only periodic-capable flag. On a channel without that capability, bit 1 always reads 0 and writes to it are ignored.
- R5: A channel matches when the counter is running and the compared counter bits equal the comparator. A one-shot channel fires on that match only, and its comparator keeps the value last written to it.
- R6: In periodic mode with value-set at 1, the first comparator write loads the absolute count of the first match. The second comparator write loads the period, and value-set then clears itself. In periodic mode with value-set at 0, a comparator write loads the period.
- R7: On every match, a periodic channel adds the stored period to its comparator, so it fires again one period later with no software write.
- R8: In 32-bit compare mode, only counter bits 31:0 are compared with comparator bits 31:0, and the comparator's upper half reads as 0. In 64-bit mode, all 64 comparator bits are stored and read back.
- R9: A level-type channel `n` sets status bit `n` (address 3) on a match. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A match in the same cycle as a clear leaves the bit set.
- R10: A level channel's interrupt line is high while its status bit is set and its interrupt enable is 1. An edge channel drives a one-clock pulse in the clock after a match while enabled, and it never sets its status bit. With the interrupt enable at 0, the line stays low, but a level channel still records the match in its status bit.
- R11: The read-data register takes the addressed word on the clock edge where the read strobe is high, and holds it otherwise. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| irq | output | NCH | One interrupt line per channel |

## Verification
Several corner cases are tested directly:
- **Counter write while running.** The counter is written while it runs and then read back after a stop at a known cycle. A design that accepts the write returns the written value instead of the elapsed tick count.
- **Periodic sequence.** Pulses are timed exactly. A design that steers comparator writes wrongly, or never clears value-set, produces pulses at the wrong cycles or none after the first.
- **32-bit compare.** The counter and comparator are given different upper halves. A design that compares all 64 bits never fires.
- **Status and enable.** The bench writes 0 to a set status bit and checks the line stays high. It also shows a disabled level channel that records a match with its line still low. A design that confuses the clear polarity or gates the status bit with the enable fails these checks.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_CAP     = 8'h00;
  localparam logic [ADDR_W-1:0] A_GCFG    = 8'h01;
  localparam logic [ADDR_W-1:0] A_CNT     = 8'h02;
  localparam logic [ADDR_W-1:0] A_STAT    = 8'h03;
  localparam int                A_CH_BASE = 8;

  // channel configuration bit positions
  localparam int B_IEN = 0;
  localparam int B_PER = 1;
  localparam int B_LVL = 2;
  localparam int B_M32 = 3;
  localparam int B_VS  = 4;
  localparam int B_CAP = 5;
endpackage

// File: rtl/evt_counter.sv
`timescale 1ns/1ps
module evt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (run)   count <= count + CNT_W'(1);
    else if (load)  count <= load_val;
  end
endmodule

// File: rtl/evt_channel.sv
`timescale 1ns/1ps
module evt_channel
  import evt_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter bit PER_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CNT_W-1:0]  count,
  input  logic              cfg_we,
  input  logic              cmp_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [7:0]        cfg_rd,
  output logic [DATA_W-1:0] cmp_rd,
  output logic              hit,
  output logic              edge_pulse,
  output logic              ien,
  output logic              lvl,
  output logic              per
);
  logic             m32, vs, vs_second;
  logic [CNT_W-1:0] cmp_q, period_q;
  logic [CNT_W-1:0] w_val;
  logic             eq;

  assign w_val = CNT_W'(wdata);

  generate
    if (CNT_W > 32) begin : g_wide
      assign eq = m32 ? (count[31:0] == cmp_q[31:0]) : (count == cmp_q);
      assign cmp_rd = m32 ? {32'd0, cmp_q[31:0]} : DATA_W'(cmp_q);
    end else begin : g_narrow
      assign eq = (count == cmp_q);
      assign cmp_rd = DATA_W'(cmp_q);
    end
  endgenerate

  assign hit = run && eq;

  // configuration word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien <= 1'b0; per <= 1'b0; lvl <= 1'b0; m32 <= 1'b0;
      vs <= 1'b0; vs_second <= 1'b0;
    end else if (cfg_we) begin
      ien       <= wdata[B_IEN];
      per       <= wdata[B_PER] & PER_OK;
      lvl       <= wdata[B_LVL];
      m32       <= wdata[B_M32];
      vs        <= wdata[B_VS];
      vs_second <= 1'b0;
    end else if (cmp_we && per && vs) begin
      if (vs_second) begin
        vs        <= 1'b0;
        vs_second <= 1'b0;
      end else begin
        vs_second <= 1'b1;
      end
    end
  end

  // comparator and period
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q    <= '0;
      period_q <= '0;
    end else if (cmp_we) begin
      if (per && vs && !vs_second) cmp_q    <= w_val;
      else if (per)                period_q <= w_val;
      else                         cmp_q    <= w_val;
    end else if (hit && per) begin
      if (m32) begin
        cmp_q        <= '0;
        cmp_q[31:0]  <= cmp_q[31:0] + period_q[31:0];
      end else begin
        cmp_q <= cmp_q + period_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) edge_pulse <= 1'b0;
    else        edge_pulse <= hit && ien && !lvl;
  end

  assign cfg_rd = {2'b00, PER_OK, vs, m32, lvl, per, ien};
endmodule

// File: rtl/evt_status.sv
`timescale 1ns/1ps
module evt_status #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_vec,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_mask,
  output logic [NCH-1:0] status
);
  logic [NCH-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_eff) | set_vec;
  end
endmodule

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer
  import evt_pkg::*;
#(
  parameter int             NCH     = 3,
  parameter int             CNT_W   = 64,
  parameter int unsigned    TICK_FS = 10000000,
  parameter logic [NCH-1:0] PER_CAP = 3'b011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NCH-1:0]    irq
);
  localparam logic [4:0]        NCH_M1   = 5'(NCH - 1);
  localparam logic              WIDE64   = (CNT_W == 64);
  localparam logic [DATA_W-1:0] CAP_WORD = {32'(TICK_FS), 18'd0, WIDE64, NCH_M1, 8'd0};

  logic             gen_en;
  logic [CNT_W-1:0] cnt_q;
  logic [NCH-1:0]   stat_q;
  logic [NCH-1:0]   ch_hit, ch_edge, ch_ien, ch_lvl, ch_per;
  logic [7:0]        ch_cfg_rd [NCH];
  logic [DATA_W-1:0] ch_cmp_rd [NCH];

  always_ff @(posedge clk) begin
    if (!rst_n)                              gen_en <= 1'b0;
    else if (reg_wr && reg_addr == A_GCFG)   gen_en <= reg_wdata[0];
  end

  evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (gen_en),
    .load     (reg_wr && reg_addr == A_CNT),
    .load_val (CNT_W'(reg_wdata)),
    .count    (cnt_q)
  );

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(A_CH_BASE + 2*n);
      localparam logic [ADDR_W-1:0] CMP_A = ADDR_W'(A_CH_BASE + 2*n + 1);
      evt_channel #(.CNT_W(CNT_W), .PER_OK(PER_CAP[n])) u_ch (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (gen_en),
        .count      (cnt_q),
        .cfg_we     (reg_wr && reg_addr == CFG_A),
        .cmp_we     (reg_wr && reg_addr == CMP_A),
        .wdata      (reg_wdata),
        .cfg_rd     (ch_cfg_rd[n]),
        .cmp_rd     (ch_cmp_rd[n]),
        .hit        (ch_hit[n]),
        .edge_pulse (ch_edge[n]),
        .ien        (ch_ien[n]),
        .lvl        (ch_lvl[n]),
        .per        (ch_per[n])
      );
    end
  endgenerate

  evt_status #(.NCH(NCH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (ch_hit & ch_lvl),
    .clr_we   (reg_wr && reg_addr == A_STAT),
    .clr_mask (reg_wdata[NCH-1:0]),
    .status   (stat_q)
  );

  assign irq = (stat_q & ch_lvl & ch_ien) | ch_edge;

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (reg_addr)
      A_CAP:   rd_next = CAP_WORD;
      A_GCFG:  rd_next = {63'd0, gen_en};
      A_CNT:   rd_next = DATA_W'(cnt_q);
      A_STAT:  rd_next = DATA_W'(stat_q);
      default: rd_next = '0;
    endcase
    for (int n = 0; n < NCH; n++) begin
      if (reg_addr == ADDR_W'(A_CH_BASE + 2*n))     rd_next = DATA_W'(ch_cfg_rd[n]);
      if (reg_addr == ADDR_W'(A_CH_BASE + 2*n + 1)) rd_next = ch_cmp_rd[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end
endmodule

// File: rtl/evt_timer_chk.sv
`timescale 1ns/1ps
module evt_timer_chk
  import evt_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int CNT_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gen_en,
  input logic [CNT_W-1:0]  count,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [NCH-1:0]    status,
  input logic [NCH-1:0]    ien,
  input logic [NCH-1:0]    lvl,
  input logic [NCH-1:0]    irq
);
  // R2: a running counter advances by exactly one; R3: writes cannot disturb it
  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en |=> count == $past(count) + CNT_W'(1));

  // R3: a stopped counter changes only through a counter write
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !(reg_wr && reg_addr == A_CNT)) |=> $stable(count));

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_a
      // R9: a status bit falls only after a write of 1 to it
      p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[i]) |-> $past(reg_wr && reg_addr == A_STAT && reg_wdata[i]));
      // R10: a disabled channel keeps its line low
      p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ien[i] && !$past(ien[i])) |-> !irq[i]);
      // R10: a settled level channel only drives its line from status
      p_lvl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[i] && lvl[i] && $past(lvl[i])) |-> status[i]);
    end
  endgenerate
endmodule

bind evt_timer evt_timer_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gen_en    (gen_en),
  .count     (cnt_q),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .status    (stat_q),
  .ien       (ch_ien),
  .lvl       (ch_lvl),
  .irq       (irq)
);

// File: tb/tb_evt_timer.sv
`timescale 1ns/1ps
module tb_evt_timer;
  localparam int          NCH     = 3;
  localparam int          CNT_W   = 64;
  localparam int unsigned TICK_FS = 10000000;
  localparam logic [63:0] CAP_EXP = (64'(TICK_FS) << 32) | (64'd1 << 13) | (64'(NCH-1) << 8);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [NCH-1:0] irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_timer #(.NCH(NCH), .CNT_W(CNT_W), .TICK_FS(TICK_FS), .PER_CAP(3'b011)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        is_rd;
    logic [7:0]  addr;
    logic [63:0] data;
    logic [7:0]  req;
  } op_t;

  localparam int NOPS = 20;
  localparam op_t TBL [NOPS] = '{
    '{1'b1, 8'h00, CAP_EXP,              8'd1},  // R1 capability layout
    '{1'b1, 8'h01, 64'd0,                8'd2},  // R2 reset state
    '{1'b1, 8'h02, 64'd0,                8'd2},  // R2 counter zero
    '{1'b1, 8'h03, 64'd0,                8'd9},  // R9 status zero
    '{1'b1, 8'h08, 64'h20,               8'd4},  // R4 capable flag
    '{1'b1, 8'h0C, 64'h00,               8'd4},  // R4 no capability
    '{1'b1, 8'h3F, 64'd0,                8'd11}, // R11 unmapped
    '{1'b0, 8'h02, 64'd100,              8'd3},
    '{1'b1, 8'h02, 64'd100,              8'd3},  // R3 load while stopped
    '{1'b0, 8'h0C, 64'h0F,               8'd4},
    '{1'b1, 8'h0C, 64'h0D,               8'd4},  // R4 periodic bit ignored
    '{1'b0, 8'h0C, 64'h00,               8'd4},
    '{1'b0, 8'h09, 64'h1_0000_0005,      8'd8},
    '{1'b0, 8'h08, 64'h08,               8'd8},
    '{1'b1, 8'h09, 64'h5,                8'd8},  // R8 upper half reads zero
    '{1'b1, 8'h08, 64'h28,               8'd4},  // R4 field readback
    '{1'b0, 8'h08, 64'h00,               8'd8},
    '{1'b1, 8'h09, 64'h1_0000_0005,      8'd8},  // R8 full width stored
    '{1'b0, 8'h02, 64'd0,                8'd3},
    '{1'b1, 8'h02, 64'd0,                8'd3}   // R3
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic        ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 irq after reset", 64'(irq), 64'd0);

    // table walk
    for (int k = 0; k < NOPS; k++) begin
      if (TBL[k].is_rd) begin
        rd(TBL[k].addr, v);
        check($sformatf("R%0d table entry %0d", TBL[k].req, k), v, TBL[k].data);
      end else begin
        wr(TBL[k].addr, TBL[k].data);
      end
    end

    // R3: write while running is ignored
    wr(8'h01, 64'd1);
    wr(8'h02, 64'd5);
    wr(8'h01, 64'd0);
    rd(8'h02, v);
    check("R3 write ignored while running", v, 64'd2);

    // R5 / R9 / R10: one-shot level channel 0
    wr(8'h02, 64'd0);
    wr(8'h09, 64'd10);
    wr(8'h08, 64'h05);
    wr(8'h01, 64'd1);
    repeat (10) @(negedge clk);
    check("R5 no fire before match", 64'(irq[0]), 64'd0);
    @(negedge clk);
    check("R10 level line on match", 64'(irq[0]), 64'd1);
    rd(8'h09, v);
    check("R5 comparator unchanged", v, 64'd10);
    rd(8'h03, v);
    check("R9 status bit set", v & 64'd1, 64'd1);
    wr(8'h03, 64'd0);
    check("R9 write zero keeps bit", 64'(irq[0]), 64'd1);
    wr(8'h03, 64'd1);
    check("R9 write one clears", 64'(irq[0]), 64'd0);
    ok = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (irq[0]) ok = 1'b0;
    end
    check("R5 fires once", 64'(ok), 64'd1);

    // R6 / R7: periodic edge channel 1
    wr(8'h01, 64'd0);
    wr(8'h02, 64'd0);
    wr(8'h08, 64'd0);
    wr(8'h03, 64'h7);
    wr(8'h0A, 64'h13);
    wr(8'h0B, 64'd20);
    wr(8'h0B, 64'd5);
    rd(8'h0A, v);
    check("R6 value-set self-clears", v, 64'h23);
    rd(8'h0B, v);
    check("R6 first write is start count", v, 64'd20);
    wr(8'h01, 64'd1);
    ok = 1'b1;
    for (int j = 1; j <= 32; j++) begin
      @(negedge clk);
      if (irq[1] !== ((j == 21) || (j == 26) || (j == 31))) begin
        ok = 1'b0;
        $display("  mismatch at cycle %0d irq1=%b", j, irq[1]);
      end
    end
    check("R7 periodic pulses at 21/26/31 (R10 edge width)", 64'(ok), 64'd1);
    rd(8'h03, v);
    check("R10 edge channel leaves status", v & 64'h2, 64'd0);

    // R8: 32-bit compare on channel 2 with differing upper halves
    wr(8'h01, 64'd0);
    wr(8'h0A, 64'd0);
    wr(8'h02, 64'h5_0000_0003);
    wr(8'h0D, 64'h7_0000_0006);
    wr(8'h0C, 64'h0D);
    wr(8'h03, 64'h7);
    rd(8'h0D, v);
    check("R8 comparator upper reads zero", v, 64'd6);
    wr(8'h01, 64'd1);
    repeat (3) @(negedge clk);
    check("R8 no match early", 64'(irq[2]), 64'd0);
    @(negedge clk);
    check("R8 low-half match fires", 64'(irq[2]), 64'd1);

    // R10: disabled level channel records status, line low
    wr(8'h01, 64'd0);
    wr(8'h03, 64'h7);
    wr(8'h0C, 64'h0C);
    wr(8'h02, 64'd3);
    wr(8'h01, 64'd1);
    ok = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (irq[2]) ok = 1'b0;
    end
    check("R10 disabled line stays low", 64'(ok), 64'd1);
    rd(8'h03, v);
    check("R10 disabled channel still sets status", v & 64'h4, 64'h4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule